// File: doc/BRIEF.md
# Operand Effective Address Generator

This block turns the addressing-mode field and operand bytes of an 8-bit accumulator-style instruction into the 16-bit address the execute stage should use. Instruction decode hands it a mode code, up to two operand bytes, the current X and Y index values and the program counter, and pulses `start`. Most modes produce their address on the next cycle. The three pointer-based modes use a small byte-read port to fetch a 16-bit little-endian pointer first.

The block also reports a one-cycle penalty flag with the result. The flag marks indexed accesses whose index addition carried into the next 256-byte page, so the sequencer can insert the extra cycle. Index arithmetic on page-zero operands wraps inside page zero. Opcode decode and instruction execution belong to neighbouring blocks.

The `pc` input always holds the address of the first operand byte, which is the byte right after the opcode.

Top module: `ea_gen`

## Requirements
- R1: During and right after synchronous active-low reset, `done`, `page_pen` and `mem_rd` are 0 and `ea` is 0.
- R2: Mode codes 0 (implied) and 1 (accumulator), and the unused codes 13, 14 and 15, produce `ea` = 0 with no penalty and no memory read.
- R3: Mode code 2 (immediate) gives `ea` = `pc`, the address of the operand byte itself.
- R4: Mode codes 3 (page zero), 4 (page zero + X) and 5 (page zero + Y) give `ea` = {0x00, (operand_lo + index) mod 256}. The penalty flag stays clear.
- R5: Mode codes 6 (absolute), 7 (absolute + X) and 8 (absolute + Y) give `ea` = ({hi,lo} + index) mod 65536. Mode 6 uses no index. `page_pen` is set when the high byte of the result differs from `hi`.
- R6: Mode code 12 (relative) gives `ea` = `pc` + 1 + the sign-extended `opnd_lo`, modulo 65536. The penalty flag stays clear.
- R7: For every mode that needs no read, `done` pulses for exactly one cycle, in the cycle after the edge that accepted `start`. `page_pen` is only ever high while `done` is high.
- R8: Mode code 9 (indirect) reads address {hi,lo} and then {hi,lo}+1, where the carry ripples into the high byte. The result is `ea` = {second byte, first byte}.
- R9: Mode code 10 (pre-indexed by X) forms the pointer z = (lo + X) mod 256. It reads {0x00,z} and then {0x00,(z+1) mod 256}, and the result is the assembled word.
- R10: Mode code 11 (post-indexed by Y) reads {0x00,lo} and then {0x00,(lo+1) mod 256}. It adds Y to the assembled word, and `page_pen` is set when the high byte changes.
- R11: A pointer fetch holds `mem_rd` high for exactly two consecutive cycles, low byte first. `mem_rdata` is taken in the same cycle that `mem_addr` is presented. `done` rises in the cycle after the second read, which is three cycles after the accepting edge.
- R12: `start` is ignored while a pointer fetch is in progress. The pending result is unchanged, and no extra `done` pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request an address computation; inputs are sampled on the accepting edge |
| mode | input | 4 | Addressing-mode code (see requirements) |
| opnd_lo | input | 8 | First operand byte (low byte, page-zero address or branch offset) |
| opnd_hi | input | 8 | Second operand byte (high byte of absolute forms) |
| idx_x | input | 8 | X index value |
| idx_y | input | 8 | Y index value |
| pc | input | 16 | Address of the first operand byte |
| mem_rd | output | 1 | Pointer byte read request |
| mem_addr | output | 16 | Pointer byte read address, 0 when idle |
| mem_rdata | input | 8 | Read data, valid in the same cycle as `mem_addr` |
| ea | output | 16 | Effective address, valid while `done` is high and held afterwards |
| done | output | 1 | One-cycle result strobe |
| page_pen | output | 1 | Page-crossing penalty, qualified by `done` |

## Verification
The assertions assume that `mem_rdata` answers the address in the same cycle, with no wait states. They also assume that `pc` and `opnd_lo` are meaningful only on the cycle `start` is accepted, so the relative-target property compares against the values sampled there. The bench keeps to these assumptions. Its memory is a pure combinational function of `mem_addr`. After each accepted request it scrambles every operand input, so that any result depending on a later input value shows up as a mismatch. It sweeps every operand byte against index values at 0x00, 0x01, 0x7F, 0x80 and 0xFF, which reaches page crossings and page-zero wraps. It also drives `start` during a pointer fetch to exercise the busy window.

// File: rtl/ea_pkg.sv
// Shared definitions for the effective address generator.
// Assumes a 4-bit mode field; codes 13..15 are treated as implied.
package ea_pkg;

    typedef enum logic [3:0] {
        EA_IMPLIED = 4'd0,
        EA_ACCUM   = 4'd1,
        EA_IMMED   = 4'd2,
        EA_ZPG     = 4'd3,
        EA_ZPG_X   = 4'd4,
        EA_ZPG_Y   = 4'd5,
        EA_ABSO    = 4'd6,
        EA_ABSO_X  = 4'd7,
        EA_ABSO_Y  = 4'd8,
        EA_IND     = 4'd9,
        EA_IND_X   = 4'd10,
        EA_IND_Y   = 4'd11,
        EA_REL     = 4'd12
    } ea_mode_e;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_LO   = 2'd1,
        SQ_HI   = 2'd2
    } seq_state_e;

endpackage

// File: rtl/ea_idx_add.sv
// Adds an unsigned index byte to a two-byte base and reports whether the
// high byte changed (page crossing). Purely combinational.
// Assumes the result wraps modulo 2**(2*DATA_W).
module ea_idx_add #(
    parameter int DATA_W = 8
) (
    input  logic [2*DATA_W-1:0] base,
    input  logic [DATA_W-1:0]   idx,
    output logic [2*DATA_W-1:0] sum,
    output logic                crossed
);
    localparam int AW = 2 * DATA_W;

    // Wide add and high-byte comparison.
    always_comb begin
        sum     = base + AW'(idx);
        crossed = (sum[AW-1:DATA_W] != base[AW-1:DATA_W]);
    end

endmodule

// File: rtl/ea_decode.sv
// Resolves the modes that need no memory access and prepares the pointer
// address and wrap rule for the three pointer-based modes.
// Assumes pc is the address of the first operand byte.
module ea_decode
    import ea_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic [3:0]          mode,
    input  logic [DATA_W-1:0]   lo,
    input  logic [DATA_W-1:0]   hi,
    input  logic [DATA_W-1:0]   x,
    input  logic [DATA_W-1:0]   y,
    input  logic [2*DATA_W-1:0] pc,
    output logic [2*DATA_W-1:0] dir_addr,
    output logic                dir_pen,
    output logic                is_ind,
    output logic                is_indy,
    output logic [2*DATA_W-1:0] ptr_addr,
    output logic                ptr_wrap
);
    localparam int AW = 2 * DATA_W;
    localparam logic [DATA_W-1:0] PAGE0 = '0;

    logic [DATA_W-1:0] abs_idx;
    logic [AW-1:0]     abs_sum;
    logic              abs_cross;
    logic [DATA_W-1:0] zx;
    logic [DATA_W-1:0] zy;
    logic [AW-1:0]     rel_off;

    // Index select for the absolute indexed forms.
    assign abs_idx = (mode == EA_ABSO_Y) ? y : x;

    ea_idx_add #(.DATA_W(DATA_W)) u_abs_add (
        .base    ({hi, lo}),
        .idx     (abs_idx),
        .sum     (abs_sum),
        .crossed (abs_cross)
    );

    // Page-zero sums wrap in the byte width; branch offset sign-extended.
    always_comb begin
        zx      = lo + x;
        zy      = lo + y;
        rel_off = {{DATA_W{lo[DATA_W-1]}}, lo};
    end

    // Per-mode selection of direct result or pointer setup.
    always_comb begin
        dir_addr = '0;
        dir_pen  = 1'b0;
        is_ind   = 1'b0;
        is_indy  = 1'b0;
        ptr_addr = '0;
        ptr_wrap = 1'b0;
        case (mode)
            EA_IMMED:  dir_addr = pc;
            EA_ZPG:    dir_addr = {PAGE0, lo};
            EA_ZPG_X:  dir_addr = {PAGE0, zx};
            EA_ZPG_Y:  dir_addr = {PAGE0, zy};
            EA_ABSO:   dir_addr = {hi, lo};
            EA_ABSO_X,
            EA_ABSO_Y: begin
                dir_addr = abs_sum;
                dir_pen  = abs_cross;
            end
            EA_REL:    dir_addr = pc + AW'(1) + rel_off;
            EA_IND: begin
                is_ind   = 1'b1;
                ptr_addr = {hi, lo};
            end
            EA_IND_X: begin
                is_ind   = 1'b1;
                ptr_wrap = 1'b1;
                ptr_addr = {PAGE0, zx};
            end
            EA_IND_Y: begin
                is_ind   = 1'b1;
                is_indy  = 1'b1;
                ptr_wrap = 1'b1;
                ptr_addr = {PAGE0, lo};
            end
            default: dir_addr = '0;
        endcase
    end

endmodule

// File: rtl/ea_ptr_seq.sv
// Fetches a little-endian pointer one byte per cycle: low byte, then high.
// Assumes rdata answers mem_addr in the same cycle. When wrap is set the
// second address stays inside the pointer's page; otherwise it carries.
module ea_ptr_seq
    import ea_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                go,
    input  logic [2*DATA_W-1:0] ptr,
    input  logic                wrap,
    input  logic [DATA_W-1:0]   rdata,
    output logic                mem_rd,
    output logic [2*DATA_W-1:0] mem_addr,
    output logic                busy,
    output logic                fin,
    output logic [2*DATA_W-1:0] word
);
    localparam int AW = 2 * DATA_W;

    seq_state_e        st;
    logic [AW-1:0]     ptr_q;
    logic              wrap_q;
    logic [DATA_W-1:0] lo_q;
    logic [AW-1:0]     nxt;

    // State progression and byte capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st     <= SQ_IDLE;
            ptr_q  <= '0;
            wrap_q <= 1'b0;
            lo_q   <= '0;
        end else begin
            case (st)
                SQ_IDLE: if (go) begin
                    st     <= SQ_LO;
                    ptr_q  <= ptr;
                    wrap_q <= wrap;
                end
                SQ_LO: begin
                    lo_q <= rdata;
                    st   <= SQ_HI;
                end
                SQ_HI:   st <= SQ_IDLE;
                default: st <= SQ_IDLE;
            endcase
        end
    end

    // Address of the high pointer byte, with or without page wrap.
    always_comb begin
        if (wrap_q)
            nxt = {ptr_q[AW-1:DATA_W], ptr_q[DATA_W-1:0] + DATA_W'(1)};
        else
            nxt = ptr_q + AW'(1);
    end

    // Read port drive and completion indication.
    always_comb begin
        mem_rd   = (st != SQ_IDLE);
        busy     = (st != SQ_IDLE);
        fin      = (st == SQ_HI);
        word     = {rdata, lo_q};
        case (st)
            SQ_LO:   mem_addr = ptr_q;
            SQ_HI:   mem_addr = nxt;
            default: mem_addr = '0;
        endcase
    end

endmodule

// File: rtl/ea_gen.sv
// Top of the effective address generator. Accepts a request when idle,
// returns direct-mode addresses one cycle later and pointer-mode addresses
// three cycles later, each with a one-cycle done strobe and penalty flag.
// Assumes inputs are valid only on the accepting cycle.
module ea_gen #(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [3:0]          mode,
    input  logic [DATA_W-1:0]   opnd_lo,
    input  logic [DATA_W-1:0]   opnd_hi,
    input  logic [DATA_W-1:0]   idx_x,
    input  logic [DATA_W-1:0]   idx_y,
    input  logic [2*DATA_W-1:0] pc,
    output logic                mem_rd,
    output logic [2*DATA_W-1:0] mem_addr,
    input  logic [DATA_W-1:0]   mem_rdata,
    output logic [2*DATA_W-1:0] ea,
    output logic                done,
    output logic                page_pen
);
    localparam int AW = 2 * DATA_W;

    logic [AW-1:0]     dir_addr;
    logic              dir_pen;
    logic              is_ind;
    logic              is_indy;
    logic [AW-1:0]     ptr_addr;
    logic              ptr_wrap;
    logic              busy;
    logic              fin;
    logic [AW-1:0]     word;
    logic              accept;
    logic              indy_q;
    logic [DATA_W-1:0] y_q;
    logic [AW-1:0]     post_sum;
    logic              post_cross;
    logic [AW-1:0]     ea_q;
    logic              done_q;
    logic              pen_q;

    ea_decode #(.DATA_W(DATA_W)) u_decode (
        .mode     (mode),
        .lo       (opnd_lo),
        .hi       (opnd_hi),
        .x        (idx_x),
        .y        (idx_y),
        .pc       (pc),
        .dir_addr (dir_addr),
        .dir_pen  (dir_pen),
        .is_ind   (is_ind),
        .is_indy  (is_indy),
        .ptr_addr (ptr_addr),
        .ptr_wrap (ptr_wrap)
    );

    // A request is taken only when no pointer fetch is running.
    assign accept = start & ~busy;

    ea_ptr_seq #(.DATA_W(DATA_W)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (accept & is_ind),
        .ptr      (ptr_addr),
        .wrap     (ptr_wrap),
        .rdata    (mem_rdata),
        .mem_rd   (mem_rd),
        .mem_addr (mem_addr),
        .busy     (busy),
        .fin      (fin),
        .word     (word)
    );

    // Hold the post-index value and mode flag for the pointer fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            indy_q <= 1'b0;
            y_q    <= '0;
        end else if (accept) begin
            indy_q <= is_indy;
            y_q    <= idx_y;
        end
    end

    ea_idx_add #(.DATA_W(DATA_W)) u_post_add (
        .base    (word),
        .idx     (y_q),
        .sum     (post_sum),
        .crossed (post_cross)
    );

    // Result register: direct modes on accept, pointer modes on last read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ea_q   <= '0;
            done_q <= 1'b0;
            pen_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            pen_q  <= 1'b0;
            if (accept && !is_ind) begin
                ea_q   <= dir_addr;
                pen_q  <= dir_pen;
                done_q <= 1'b1;
            end else if (fin) begin
                ea_q   <= indy_q ? post_sum : word;
                pen_q  <= indy_q & post_cross;
                done_q <= 1'b1;
            end
        end
    end

    assign ea       = ea_q;
    assign done     = done_q;
    assign page_pen = pen_q;

endmodule

// File: rtl/ea_gen_chk.sv
// Property checker for ea_gen, attached by bind. Observes ports only.
// Assumes mem_rdata is a same-cycle response and start is never X.
module ea_gen_chk
    import ea_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                start,
    input logic [3:0]          mode,
    input logic [DATA_W-1:0]   opnd_lo,
    input logic [2*DATA_W-1:0] pc,
    input logic                mem_rd,
    input logic [2*DATA_W-1:0] mem_addr,
    input logic [2*DATA_W-1:0] ea,
    input logic                done,
    input logic                page_pen
);
    localparam int AW = 2 * DATA_W;

    logic          ind_m;
    logic          imp_m;
    logic          zp_m;
    logic          taken;
    logic [AW-1:0] rel_tgt;

    // Mode classes and the branch target seen at the request cycle.
    always_comb begin
        ind_m   = (mode == EA_IND) || (mode == EA_IND_X) || (mode == EA_IND_Y);
        imp_m   = (mode == EA_IMPLIED) || (mode == EA_ACCUM) || (mode > EA_REL);
        zp_m    = (mode == EA_ZPG) || (mode == EA_ZPG_X) || (mode == EA_ZPG_Y);
        taken   = start && !mem_rd;
        rel_tgt = pc + AW'(1) + {{DATA_W{opnd_lo[DATA_W-1]}}, opnd_lo};
    end

    // R7: direct modes answer on the next cycle
    a_r7_direct_done: assert property (@(posedge clk) disable iff (!rst_n)
        taken && !ind_m |=> done);

    // R7: penalty is only reported alongside a result
    a_r7_pen_qualified: assert property (@(posedge clk) disable iff (!rst_n)
        page_pen |-> done);

    // R2: implied-class codes give zero and touch no memory
    a_r2_implied_zero: assert property (@(posedge clk) disable iff (!rst_n)
        taken && imp_m |=> (ea == '0) && !page_pen && !mem_rd);

    // R4: page-zero modes stay in page zero
    a_r4_zp_page0: assert property (@(posedge clk) disable iff (!rst_n)
        taken && zp_m |=> (ea[AW-1:DATA_W] == '0) && !page_pen);

    // R6: relative target from the request-cycle pc and offset
    a_r6_rel_target: assert property (@(posedge clk) disable iff (!rst_n)
        taken && (mode == EA_REL) |=> ea == $past(rel_tgt));

    // R11: pointer modes begin reading next cycle, with no result yet
    a_r11_fetch_begins: assert property (@(posedge clk) disable iff (!rst_n)
        taken && ind_m |=> mem_rd && !done);

    // R11: reads come in pairs
    a_r11_second_read: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_rd) |=> mem_rd);

    // R11: never a third consecutive read
    a_r11_read_pair: assert property (@(posedge clk) disable iff (!rst_n)
        $past(mem_rd, 2) && $past(mem_rd) |-> !mem_rd);

    // R11: the result follows the last read
    a_r11_done_after_reads: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(mem_rd) |-> done);

    // R11: idle read port shows address zero
    a_r11_idle_addr: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd |-> (mem_addr == '0));

endmodule

bind ea_gen ea_gen_chk #(.DATA_W(DATA_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .start    (start),
    .mode     (mode),
    .opnd_lo  (opnd_lo),
    .pc       (pc),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .ea       (ea),
    .done     (done),
    .page_pen (page_pen)
);

// File: tb/ea_gen_test.sv
module ea_gen_test;
    import ea_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [3:0]  mode = 4'd0;
    logic [7:0]  opnd_lo = 8'd0;
    logic [7:0]  opnd_hi = 8'd0;
    logic [7:0]  idx_x = 8'd0;
    logic [7:0]  idx_y = 8'd0;
    logic [15:0] pc = 16'd0;
    logic        mem_rd;
    logic [15:0] mem_addr;
    logic [7:0]  mem_rdata;
    logic [15:0] ea;
    logic        done;
    logic        page_pen;

    int checks = 0;
    int fails  = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // Bench memory: a fixed arithmetic pattern of the address.
    function automatic logic [7:0] mem_f(input logic [15:0] a);
        logic [7:0] h;
        h = a[15:8] * 8'd29;
        return a[7:0] ^ h ^ 8'h6B;
    endfunction

    always_comb mem_rdata = mem_f(mem_addr);

    ea_gen uut (
        .clk(clk), .rst_n(rst_n), .start(start), .mode(mode),
        .opnd_lo(opnd_lo), .opnd_hi(opnd_hi), .idx_x(idx_x), .idx_y(idx_y),
        .pc(pc), .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .ea(ea), .done(done), .page_pen(page_pen)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // One request: compute expectations, drive, observe reads and result.
    task automatic run_op(input logic [3:0] tm, input logic [7:0] tlo,
                          input logic [7:0] thi, input logic [7:0] tx,
                          input logic [7:0] ty, input logic [15:0] tpc,
                          input string req);
        logic [15:0] e_ea;
        logic        e_pen;
        int          e_nrd;
        logic [15:0] e_a0;
        logic [15:0] e_a1;
        logic [15:0] w;
        logic [7:0]  z;
        logic [15:0] ra0;
        logic [15:0] ra1;
        int          cyc;
        int          nrd;
        e_ea = 16'h0; e_pen = 1'b0; e_nrd = 0; e_a0 = 16'h0; e_a1 = 16'h0;
        case (tm)
            4'd2: e_ea = tpc;
            4'd3: e_ea = {8'h00, tlo};
            4'd4: begin z = tlo + tx; e_ea = {8'h00, z}; end
            4'd5: begin z = tlo + ty; e_ea = {8'h00, z}; end
            4'd6: e_ea = {thi, tlo};
            4'd7, 4'd8: begin
                e_ea  = {thi, tlo} + {8'h00, (tm == 4'd7) ? tx : ty};
                e_pen = (e_ea[15:8] != thi);
            end
            4'd9: begin
                e_nrd = 2; e_a0 = {thi, tlo}; e_a1 = e_a0 + 16'd1;
                e_ea = {mem_f(e_a1), mem_f(e_a0)};
            end
            4'd10: begin
                z = tlo + tx; e_nrd = 2; e_a0 = {8'h00, z};
                z = z + 8'd1; e_a1 = {8'h00, z};
                e_ea = {mem_f(e_a1), mem_f(e_a0)};
            end
            4'd11: begin
                z = tlo + 8'd1; e_nrd = 2; e_a0 = {8'h00, tlo}; e_a1 = {8'h00, z};
                w = {mem_f(e_a1), mem_f(e_a0)};
                e_ea = w + {8'h00, ty};
                e_pen = (e_ea[15:8] != w[15:8]);
            end
            4'd12: e_ea = tpc + 16'd1 + {{8{tlo[7]}}, tlo};
            default: e_ea = 16'h0;
        endcase
        @(negedge clk);
        mode = tm; opnd_lo = tlo; opnd_hi = thi; idx_x = tx; idx_y = ty; pc = tpc;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        mode = ~tm; opnd_lo = ~tlo; opnd_hi = tlo; idx_x = ~ty; idx_y = ~tx; pc = ~tpc;
        cyc = 1; nrd = 0; ra0 = 16'h0; ra1 = 16'h0;
        while (!done && cyc < 8) begin
            if (mem_rd) begin
                if (nrd == 0) ra0 = mem_addr;
                if (nrd == 1) ra1 = mem_addr;
                nrd++;
            end
            @(negedge clk);
            cyc++;
        end
        chk(cyc == ((e_nrd == 2) ? 3 : 1), {req, " R7/R11 latency"}, cyc, (e_nrd == 2) ? 3 : 1);
        chk(ea == e_ea, {req, " address"}, ea, e_ea);
        chk(page_pen == e_pen, {req, " penalty"}, page_pen, e_pen);
        chk(nrd == e_nrd, {req, " R11 read count"}, nrd, e_nrd);
        if (e_nrd == 2) begin
            chk(ra0 == e_a0, {req, " R11 low pointer address"}, ra0, e_a0);
            chk(ra1 == e_a1, {req, " R11 high pointer address"}, ra1, e_a1);
        end
        @(negedge clk);
        chk(!done && !page_pen, {req, " R7 single pulse"}, {done, page_pen}, 0);
    endtask

    // Watchdog: a hang counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog: actual timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] ilist [5];
        ilist[0] = 8'h00; ilist[1] = 8'h01; ilist[2] = 8'h7F;
        ilist[3] = 8'h80; ilist[4] = 8'hFF;

        repeat (3) @(negedge clk);
        chk(!done && !page_pen && !mem_rd && ea == 16'h0, "R1 reset state",
            {done, page_pen, mem_rd, ea}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!done && !mem_rd && ea == 16'h0, "R1 after reset", {done, mem_rd, ea}, 0);

        // R2: implied, accumulator and unused codes
        run_op(4'd0, 8'h12, 8'h34, 8'h56, 8'h78, 16'h9ABC, "R2 implied");
        run_op(4'd1, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 16'hFFFF, "R2 accumulator");
        run_op(4'd13, 8'h80, 8'h01, 8'h02, 8'h03, 16'h1000, "R2 code13");
        run_op(4'd14, 8'h01, 8'h80, 8'h02, 8'h03, 16'h2000, "R2 code14");
        run_op(4'd15, 8'hAA, 8'h55, 8'hF0, 8'h0F, 16'h3000, "R2 code15");

        // R3: immediate
        run_op(4'd2, 8'h00, 8'h00, 8'h00, 8'h00, 16'h0000, "R3 immediate");
        run_op(4'd2, 8'h11, 8'h22, 8'h33, 8'h44, 16'hFFFF, "R3 immediate");
        run_op(4'd2, 8'h11, 8'h22, 8'h33, 8'h44, 16'h80FE, "R3 immediate");

        // R4 R5 R6 R8 R9 R10: sweep every operand byte against index corners
        for (int lo = 0; lo < 256; lo++) begin
            run_op(4'd3, 8'(lo), 8'h5A, 8'hFF, 8'hFF, 16'h0000, "R4 page zero");
            run_op(4'd6, 8'(lo), 8'(lo) ^ 8'hC3, 8'h00, 8'h00, 16'h0000, "R5 absolute");
            for (int k = 0; k < 5; k++) begin
                run_op(4'd4, 8'(lo), 8'h77, ilist[k], 8'h00, 16'h0000, "R4 page zero X");
                run_op(4'd5, 8'(lo), 8'h77, 8'h00, ilist[k], 16'h0000, "R4 page zero Y");
                run_op(4'd7, 8'(lo), 8'(lo) ^ 8'h3C, ilist[k], 8'h00, 16'h0000, "R5 absolute X");
                run_op(4'd8, 8'(lo), 8'(lo) ^ 8'hE1, 8'h00, ilist[k], 16'h0000, "R5 absolute Y");
                run_op(4'd12, 8'(lo), 8'h00, 8'h00, 8'h00, {ilist[k], 8'(lo) ^ ilist[k]}, "R6 relative");
                run_op(4'd9, 8'(lo), ilist[k], 8'h00, 8'h00, 16'h0000, "R8 indirect");
                run_op(4'd10, 8'(lo), 8'h99, ilist[k], 8'h00, 16'h0000, "R9 pre-indexed X");
                run_op(4'd11, 8'(lo), 8'h99, 8'h00, ilist[k], 16'h0000, "R10 post-indexed Y");
            end
        end

        // R12: start held during a pointer fetch is ignored
        begin
            logic [15:0] w;
            logic [15:0] e_ea;
            w = {mem_f(16'h0041), mem_f(16'h0040)};
            e_ea = w + 16'h00F0;
            @(negedge clk);
            mode = 4'd11; opnd_lo = 8'h40; idx_y = 8'hF0; start = 1'b1;
            @(negedge clk);
            mode = 4'd3; opnd_lo = 8'h99; idx_y = 8'h01;
            chk(!done && mem_rd, "R12 fetch running", {done, mem_rd}, 1);
            @(negedge clk);
            chk(!done && mem_rd, "R12 busy request ignored", {done, mem_rd}, 1);
            start = 1'b0;
            @(negedge clk);
            chk(done && ea == e_ea, "R12 pending result kept", ea, e_ea);
            chk(page_pen == (e_ea[15:8] != w[15:8]), "R12 penalty kept", page_pen,
                e_ea[15:8] != w[15:8]);
            @(negedge clk);
            chk(!done && ea == e_ea && !mem_rd, "R12 no extra result", {done, ea}, {1'b0, e_ea});
        end

        finished = 1'b1;
        summary();
        $finish;
    end

endmodule